// File: doc/BRIEF.md
# Multi-Width 128-bit Integer ALU

This block is the integer execute stage of a machine whose registers are 128 bits wide. It is purely combinational. It takes two 128-bit operands, an operation code, a width select and a shift amount source, and it returns a 128-bit result in the same cycle.

The width select picks one of three modes. In full mode every bit of both operands is used. In double mode only the low 64 bits are used, and in word mode only the low 32 bits. A narrow-mode result is always sign-extended to 128 bits from the top bit of its active width. This lets one datapath serve the full-width instructions and both families of narrow instructions.

A shift takes its amount either from a 7-bit immediate field or from the low bits of the second operand. The amount is masked to the range that the active width allows.

Top module: `wide_int_alu`

## Requirements
- R1: ADD (op code 0) and SUB (op code 1) give the operand sum or difference modulo 2^N, where N is the active width. No flag is raised on overflow.
- R2: Width code 0 is full 128-bit mode, code 1 is 64-bit mode and code 2 is 32-bit mode. Code 3 behaves as full mode. In a narrow mode, operand bits above the active width have no effect on the result.
- R3: In 64-bit mode result bits 127:64 all equal result bit 63. In 32-bit mode result bits 127:32 all equal result bit 31.
- R4: The shift amount is masked to its low 7 bits in full mode, its low 6 bits in 64-bit mode and its low 5 bits in 32-bit mode. In full mode an amount of 127 is honoured.
- R5: When amt_sel_imm_i is 1, the shift amount comes from imm_amt_i. When it is 0, the amount comes from b_i[6:0].
- R6: SLL (op code 2) shifts left and fills with zeros. SRL (op code 3) shifts the active-width value right and fills with zeros. A shift by 0 returns the operand, narrowed and then sign-extended.
- R7: SRA (op code 4) fills from the sign bit of the active width: bit 127, bit 63 or bit 31.
- R8: AND (op code 5), OR (op code 6) and XOR (op code 7) act bit by bit on the active width.
- R9: SLT (op code 8) compares as signed and SLTU (op code 9) compares as unsigned. Both return 1 when a < b and 0 otherwise, with bits 127:1 equal to zero.
- R10: Op codes 10 to 15 produce a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand; its low 7 bits are the register shift amount |
| imm_amt_i | input | 7 | Immediate shift amount |
| amt_sel_imm_i | input | 1 | 1 selects the immediate amount, 0 selects the register amount |
| op_i | input | 4 | Operation code |
| width_i | input | 2 | Width select: 0 full, 1 64-bit, 2 32-bit, 3 full |
| result_o | output | 128 | Result |

## Verification
The block has no state, so any internal fault shows at result_o within the same cycle as the inputs that excite it.

Each kind of fault has its own signature:
- A wrong amount mask or amount source shows as a result shifted by the wrong distance. Amounts with high bits set in narrow modes expose it, and so does a register amount that differs from the immediate.
- A wrong fill bit in the shifter shows only for negative narrow operands or for shifts that cross into the upper half.
- A wrong extension shows in the upper result bits of any narrow operation whose active sign bit is set.

The bench sends every operation, in every width, against a model built on native 32-bit, 64-bit and 128-bit types. The directed cases pin down amounts of 0 and the maximum for each width.

// File: rtl/wia_pkg.sv
`timescale 1ns/1ps
package wia_pkg;
  localparam int XLEN = 128;
  localparam int DLEN = 64;
  localparam int WLEN = 32;
  localparam int SHW  = $clog2(XLEN);
  localparam int OPW  = 4;
  localparam int WSW  = 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SRL  = 4'd3,
    OP_SRA  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9
  } alu_op_e;

  typedef enum logic [WSW-1:0] {
    WD_FULL = 2'd0,
    WD_DBL  = 2'd1,
    WD_WORD = 2'd2,
    WD_RSVD = 2'd3
  } width_e;

  // Keep the low active-width bits and fill the rest with the active sign bit
  // (sgn = 1) or with zeros (sgn = 0). Full and reserved modes pass v through.
  function automatic logic [XLEN-1:0] extend_low(input logic [XLEN-1:0] v,
                                                 input logic [WSW-1:0] wsel,
                                                 input logic sgn);
    logic [XLEN-1:0] r;
    case (wsel)
      WD_DBL:  r = {{(XLEN-DLEN){sgn & v[DLEN-1]}}, v[DLEN-1:0]};
      WD_WORD: r = {{(XLEN-WLEN){sgn & v[WLEN-1]}}, v[WLEN-1:0]};
      default: r = v;
    endcase
    return r;
  endfunction

  // Clip a raw shift amount to the range of the active width.
  function automatic logic [SHW-1:0] mask_amount(input logic [SHW-1:0] raw,
                                                 input logic [WSW-1:0] wsel);
    logic [SHW-1:0] r;
    case (wsel)
      WD_DBL:  r = raw & SHW'(DLEN-1);
      WD_WORD: r = raw & SHW'(WLEN-1);
      default: r = raw;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] bit_reverse(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction
endpackage

// File: rtl/wia_operand_prep.sv
`timescale 1ns/1ps
module wia_operand_prep
  import wia_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [WSW-1:0]  width_i,
  output logic [XLEN-1:0] a_sx_o,
  output logic [XLEN-1:0] a_zx_o,
  output logic [XLEN-1:0] b_sx_o,
  output logic [XLEN-1:0] b_zx_o
);
  assign a_sx_o = extend_low(a_i, width_i, 1'b1);
  assign a_zx_o = extend_low(a_i, width_i, 1'b0);
  assign b_sx_o = extend_low(b_i, width_i, 1'b1);
  assign b_zx_o = extend_low(b_i, width_i, 1'b0);
endmodule

// File: rtl/wia_shifter.sv
`timescale 1ns/1ps
module wia_shifter
  import wia_pkg::*;
(
  input  logic [XLEN-1:0] val_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            fill_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] stage [SHW+1];
  logic            fill_eff;

  // A left shift is a right shift of the bit-reversed value, filling with zeros.
  assign stage[0] = left_i ? bit_reverse(val_i) : val_i;
  assign fill_eff = left_i ? 1'b0 : fill_i;

  for (genvar g = 0; g < SHW; g++) begin : g_stage
    localparam int STEP = 1 << g;
    assign stage[g+1] = amt_i[g] ? {{STEP{fill_eff}}, stage[g][XLEN-1:STEP]}
                                 : stage[g];
  end

  assign res_o = left_i ? bit_reverse(stage[SHW]) : stage[SHW];
endmodule

// File: rtl/wia_arith.sv
`timescale 1ns/1ps
module wia_arith
  import wia_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic [XLEN-1:0] a_sx_i,
  input  logic [XLEN-1:0] b_sx_i,
  input  logic [XLEN-1:0] a_zx_i,
  input  logic [XLEN-1:0] b_zx_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  logic [XLEN:0] diff_s;
  logic [XLEN:0] diff_u;

  assign sum_o  = a_i + (sub_i ? ~b_i : b_i) + XLEN'(sub_i);
  // One extra bit turns each comparison into a borrow from a subtraction.
  assign diff_s = {a_sx_i[XLEN-1], a_sx_i} - {b_sx_i[XLEN-1], b_sx_i};
  assign diff_u = {1'b0, a_zx_i} - {1'b0, b_zx_i};
  assign lt_s_o = diff_s[XLEN];
  assign lt_u_o = diff_u[XLEN];
endmodule

// File: rtl/wide_int_alu.sv
`timescale 1ns/1ps
module wide_int_alu
  import wia_pkg::*;
(
  input  logic [127:0] a_i,
  input  logic [127:0] b_i,
  input  logic [6:0]   imm_amt_i,
  input  logic         amt_sel_imm_i,
  input  logic [3:0]   op_i,
  input  logic [1:0]   width_i,
  output logic [127:0] result_o
);
  alu_op_e         op;
  logic [XLEN-1:0] a_sx, a_zx, b_sx, b_zx;
  logic [SHW-1:0]  amt_raw;
  logic [SHW-1:0]  shamt_eff;
  logic            shift_left;
  logic            shift_fill;
  logic [XLEN-1:0] shift_src;
  logic [XLEN-1:0] shift_res;
  logic [XLEN-1:0] sum;
  logic            lt_s, lt_u;
  logic            narrow;
  logic [XLEN-1:0] raw_res;

  assign op      = alu_op_e'(op_i);
  assign narrow  = (width_i == WD_DBL) || (width_i == WD_WORD);
  assign amt_raw = amt_sel_imm_i ? imm_amt_i : b_i[SHW-1:0];
  assign shamt_eff = mask_amount(amt_raw, width_i);

  wia_operand_prep u_prep (
    .a_i(a_i), .b_i(b_i), .width_i(width_i),
    .a_sx_o(a_sx), .a_zx_o(a_zx), .b_sx_o(b_sx), .b_zx_o(b_zx)
  );

  assign shift_left = (op == OP_SLL);
  assign shift_fill = (op == OP_SRA) & a_sx[XLEN-1];
  always_comb begin
    case (op)
      OP_SLL:  shift_src = a_i;
      OP_SRA:  shift_src = a_sx;
      default: shift_src = a_zx;
    endcase
  end

  wia_shifter u_shift (
    .val_i(shift_src), .amt_i(shamt_eff), .left_i(shift_left),
    .fill_i(shift_fill), .res_o(shift_res)
  );

  wia_arith u_arith (
    .a_i(a_i), .b_i(b_i), .sub_i(op == OP_SUB),
    .a_sx_i(a_sx), .b_sx_i(b_sx), .a_zx_i(a_zx), .b_zx_i(b_zx),
    .sum_o(sum), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:         raw_res = sum;
      OP_SLL, OP_SRL, OP_SRA: raw_res = shift_res;
      OP_AND:                 raw_res = a_i & b_i;
      OP_OR:                  raw_res = a_i | b_i;
      OP_XOR:                 raw_res = a_i ^ b_i;
      OP_SLT:                 raw_res = XLEN'(lt_s);
      OP_SLTU:                raw_res = XLEN'(lt_u);
      default:                raw_res = '0;
    endcase
  end

  assign result_o = narrow ? extend_low(raw_res, width_i, 1'b1) : raw_res;
endmodule

// File: rtl/wia_checker.sv
`timescale 1ns/1ps
module wia_checker (
  input logic [127:0] a_i,
  input logic [127:0] b_i,
  input logic [3:0]   op_i,
  input logic [1:0]   width_i,
  input logic [6:0]   shamt,
  input logic [127:0] result_o
);
  always_comb begin
    if (width_i == 2'd2)
      p_sext_word_r3: assert (result_o[127:32] == {96{result_o[31]}})
        else $error("word result not sign-extended");
    if (width_i == 2'd1)
      p_sext_dbl_r3: assert (result_o[127:64] == {64{result_o[63]}})
        else $error("double result not sign-extended");
    if (width_i == 2'd2)
      p_amt_word_r4: assert (shamt < 7'd32) else $error("word amount out of range");
    if (width_i == 2'd1)
      p_amt_dbl_r4: assert (shamt < 7'd64) else $error("double amount out of range");
    if (op_i == 4'd8 || op_i == 4'd9)
      p_bool_r9: assert (result_o[127:1] == '0) else $error("compare not 0/1");
    if (op_i == 4'd0 && width_i == 2'd0)
      p_add_inv_r1: assert (result_o - b_i == a_i) else $error("add inverse broken");
    if (op_i == 4'd4 && width_i == 2'd0)
      p_sra_sign_r7: assert (result_o[127] == a_i[127]) else $error("sra sign lost");
    if (op_i == 4'd2 && width_i == 2'd0 && shamt == 7'd0)
      p_zero_shift_r6: assert (result_o == a_i) else $error("zero shift altered value");
    if (op_i > 4'd9)
      p_undef_r10: assert (result_o == '0) else $error("undefined op nonzero");
  end
endmodule

bind wide_int_alu wia_checker u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .width_i(width_i),
  .shamt(shamt_eff), .result_o(result_o)
);

// File: tb/wide_int_alu_test.sv
`timescale 1ns/1ps
module wide_int_alu_test;
  localparam real CLK_PERIOD = 5.0;

  typedef struct {
    logic [127:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic [6:0]   imm = '0;
  logic         use_imm = 1'b0;
  logic [3:0]   op = '0;
  logic [1:0]   wd = '0;
  logic [127:0] res;
  item_t        q[$];
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_int_alu uut (
    .a_i(a), .b_i(b), .imm_amt_i(imm), .amt_sel_imm_i(use_imm),
    .op_i(op), .width_i(wd), .result_o(res)
  );

  function automatic logic [127:0] ref_model(input logic [3:0] o, input logic [1:0] w,
      input logic [127:0] x128, input logic [127:0] y128,
      input logic [6:0] im, input logic ui);
    logic [6:0] raw;
    int unsigned s;
    raw = ui ? im : y128[6:0];
    if (w == 2'd2) begin
      int x, y, r;
      x = x128[31:0]; y = y128[31:0]; s = raw & 7'd31;
      case (o)
        0: r = x + y;  1: r = x - y;  2: r = x << s;
        3: r = int'($unsigned(x) >> s);  4: r = x >>> s;
        5: r = x & y;  6: r = x | y;  7: r = x ^ y;
        8: r = (x < y) ? 1 : 0;
        9: r = ($unsigned(x) < $unsigned(y)) ? 1 : 0;
        default: r = 0;
      endcase
      return {{96{r[31]}}, r};
    end else if (w == 2'd1) begin
      longint x, y, r;
      x = x128[63:0]; y = y128[63:0]; s = raw & 7'd63;
      case (o)
        0: r = x + y;  1: r = x - y;  2: r = x << s;
        3: r = longint'($unsigned(x) >> s);  4: r = x >>> s;
        5: r = x & y;  6: r = x | y;  7: r = x ^ y;
        8: r = (x < y) ? 1 : 0;
        9: r = ($unsigned(x) < $unsigned(y)) ? 1 : 0;
        default: r = 0;
      endcase
      return {{64{r[63]}}, r};
    end else begin
      logic signed [127:0] x, y, r;
      x = x128; y = y128; s = raw;
      case (o)
        0: r = x + y;  1: r = x - y;  2: r = x << s;
        3: r = $signed($unsigned(x) >> s);  4: r = x >>> s;
        5: r = x & y;  6: r = x | y;  7: r = x ^ y;
        8: r = (x < y) ? 128'sd1 : 128'sd0;
        9: r = ($unsigned(x) < $unsigned(y)) ? 128'sd1 : 128'sd0;
        default: r = '0;
      endcase
      return r;
    end
  endfunction

  function automatic string tag_for(input logic [3:0] o);
    case (o)
      0, 1:    return "R1";
      2, 3:    return "R6";
      4:       return "R7";
      5, 6, 7: return "R8";
      8, 9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  // Driver: applies one vector just after a rising edge and queues its expectation.
  task automatic apply(input logic [3:0] o, input logic [1:0] w, input logic [127:0] x,
                       input logic [127:0] y, input logic [6:0] im, input logic ui,
                       input string tag);
    item_t it;
    @(posedge clk);
    #1;
    op = o; wd = w; a = x; b = y; imm = im; use_imm = ui;
    it.exp = ref_model(o, w, x, y, im, ui);
    it.tag = tag;
    q.push_back(it);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Monitor: compares at each falling edge, away from the driving edge.
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (res !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, res, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Idle state with all-zero inputs (R1: 0 + 0 = 0).
    #2;
    checks++;
    if (res !== '0) begin
      fails++;
      $display("FAIL R1: got %h expected %h", res, 128'h0);
    end
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R2 R3: the word mode ignores upper garbage and sign-extends an overflow.
    apply(4'd0, 2'd2, {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h7FFF_FFFF},
          {96'h1234_5678_9ABC_DEF0_1111_2222, 32'h1}, 7'd0, 1'b0, "R2");
    apply(4'd0, 2'd2, 128'h7FFF_FFFF, 128'h1, 7'd0, 1'b0, "R3");
    apply(4'd0, 2'd1, 128'h7FFF_FFFF_FFFF_FFFF, 128'h1, 7'd0, 1'b0, "R3");
    apply(4'd1, 2'd0, 128'h0, 128'h1, 7'd0, 1'b0, "R1");
    apply(4'd5, 2'd3, {128{1'b1}}, 128'h5A, 7'd0, 1'b0, "R2");
    // R4: the maximum amount per width, and masking of high amount bits.
    apply(4'd2, 2'd0, 128'h1, 128'h7F, 7'd0, 1'b0, "R4");
    apply(4'd3, 2'd2, 128'hFFFF_FFFF, 128'h7F, 7'd0, 1'b0, "R4");
    apply(4'd3, 2'd1, {64'h0, 64'h8000_0000_0000_0000}, 128'h0, 7'h7F, 1'b1, "R4");
    apply(4'd2, 2'd2, 128'h3, 128'h0, 7'h21, 1'b1, "R4");
    // R5: the amount source select.
    apply(4'd3, 2'd0, 128'hF000, 128'h3, 7'd5, 1'b1, "R5");
    apply(4'd3, 2'd0, 128'hF000, 128'h3, 7'd5, 1'b0, "R5");
    // R6 R7: zero shifts and the fill bit per width.
    apply(4'd3, 2'd2, 128'h8000_0001, 128'h0, 7'd0, 1'b1, "R6");
    apply(4'd4, 2'd0, {1'b1, 127'h0}, 128'h0, 7'd127, 1'b1, "R7");
    apply(4'd4, 2'd2, 128'h8000_0000, 128'h0, 7'd4, 1'b1, "R7");
    apply(4'd4, 2'd1, {64'h0, 64'hC000_0000_0000_0000}, 128'h0, 7'd63, 1'b1, "R7");
    apply(4'd4, 2'd0, {64'h0, 64'h8000_0000_0000_0000}, 128'h0, 7'd8, 1'b1, "R7");
    // R9: extremes of the signed and unsigned compares.
    apply(4'd8, 2'd0, {1'b1, 127'h0}, 128'h0, 7'd0, 1'b0, "R9");
    apply(4'd9, 2'd0, {128{1'b1}}, 128'h0, 7'd0, 1'b0, "R9");
    apply(4'd8, 2'd2, 128'h8000_0000, 128'h1, 7'd0, 1'b0, "R9");
    // R10: an undefined op code.
    apply(4'd15, 2'd0, rnd128(), rnd128(), 7'd3, 1'b0, "R10");

    // Sweep every op and width with random operands.
    for (int w = 0; w < 3; w++)
      for (int o = 0; o < 12; o++)
        for (int k = 0; k < 6; k++)
          apply(o[3:0], w[1:0], rnd128(), rnd128(), 7'($urandom), 1'($urandom),
                tag_for(o[3:0]));

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule